// File: doc/BRIEF.md
# Beat-Frequency Run-Length Counter with Clock-Domain Handoff

This block measures how many consecutive ones appear in a one-bit sample stream. The stream is produced by a capture flop that is clocked by a sampling clock and whose data input is a second clock. That second clock runs at a slightly different frequency, so the captured bit forms long alternating runs of ones and zeros. All counting is done in the sampling-clock domain. When a run of ones ends, its length becomes a finished count.

Each finished count is parked in a hold register, and a toggle flag is flipped. The flag is carried into the system-clock domain through a chain of synchronizer flops. An edge detector on the synchronized flag produces a one-cycle valid strobe, and the held count is captured alongside it.

The counter saturates only its top bit. Once a run reaches half of the count range, the top bit stays set and the low bits keep wrapping, so software can recover long runs by arithmetic. Consecutive runs are assumed to be far apart compared with the handoff latency.

Top module: `beat_run_counter`

## Requirements
- R1: After reset, `validOut` is 0 and `countOut` is 0.
- R2: A run of N ones with N below 128 is reported once as `countOut` = N.
- R3: Only the top count bit saturates, so the value after 0xFF is 0x80. A run of N ones with N of 128 or more is reported as 128 + (N mod 128).
- R4: A run that is a single one sample long is reported with the value 1.
- R5: Samples of zero that follow a finished run produce no further `validOut` pulse, however long they last.
- R6: Each finished run of ones gives exactly one `validOut` pulse, and that pulse lasts one system-clock cycle.
- R7: `countOut` changes only in a cycle where `validOut` is 1, and it holds its value between pulses.
- R8: A single zero sample between two runs of ones closes the first run, and both runs are reported in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sampleClk | input | 1 | Sampling clock that clocks the capture flop and the counter |
| sysClk | input | 1 | System clock for the receiving side |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| sampleIn | input | 1 | Data input of the capture flop (the second clock) |
| countOut | output | 8 | Length of the last finished run of ones |
| validOut | output | 1 | One-cycle strobe when a new count is presented |

## Verification
The bench builds the block with its default parameters: an 8-bit count and a two-flop synchronizer. With an 8-bit count, runs of up to about 400 samples take the top bit through its sticky state and wrap the low bits more than once. The same settings make both the 0xFF-to-0x80 step and runs of length 1 reachable within a short simulation. The two clocks run at unrelated periods, so the toggle crosses the synchronizer at varying phases.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef struct packed {
    logic incCnt;    // a one was captured this cycle
    logic endRun;    // first zero after a run of ones
    logic clearCnt;  // zero after zero, keep count at 0
  } brc_strobe_t;
endpackage

// File: rtl/brc_ctrl.sv
module brc_ctrl
  import brc_pkg::*;
(
  input  logic        sampleClk,
  input  logic        rstN,
  input  logic        sampleIn,
  output brc_strobe_t strobes
);
  logic capQ;
  logic prevQ;

  always_ff @(posedge sampleClk or negedge rstN) begin
    if (!rstN) begin
      capQ  <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      capQ  <= sampleIn;
      prevQ <= capQ;
    end
  end

  always_comb begin
    strobes.incCnt   = capQ;
    strobes.endRun   = !capQ && prevQ;
    strobes.clearCnt = !capQ && !prevQ;
  end

  // R6
  end_after_ones_chk: assert property (@(posedge sampleClk) disable iff (!rstN)
    strobes.endRun |-> $past(strobes.incCnt));
endmodule

// File: rtl/brc_dpath.sv
module brc_dpath
  import brc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             sampleClk,
  input  logic             rstN,
  input  brc_strobe_t      strobes,
  output logic [CNT_W-1:0] holdOut,
  output logic             tglOut
);
  localparam int LOW_W = CNT_W - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sum;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    sum     = cnt + 1'b1;
    cntNext = {sum[CNT_W-1] | cnt[CNT_W-1], sum[LOW_W-1:0]};
  end

  always_ff @(posedge sampleClk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      holdOut <= '0;
      tglOut  <= 1'b0;
    end else begin
      if (strobes.incCnt) begin
        cnt <= cntNext;
      end else if (strobes.endRun) begin
        holdOut <= cnt;
        tglOut  <= !tglOut;
        cnt     <= '0;
      end else if (strobes.clearCnt) begin
        cnt <= '0;
      end
    end
  end

  // R3
  msb_sticky_chk: assert property (@(posedge sampleClk) disable iff (!rstN)
    (cnt[CNT_W-1] && strobes.incCnt) |=> cnt[CNT_W-1]);

  // R2
  inc_step_chk: assert property (@(posedge sampleClk) disable iff (!rstN)
    (strobes.incCnt && !cnt[CNT_W-1]) |=> (cnt == CNT_W'($past(cnt) + 1)));

  // R5
  idle_zero_chk: assert property (@(posedge sampleClk) disable iff (!rstN)
    strobes.clearCnt |=> $stable(tglOut));
endmodule

// File: rtl/brc_sync.sv
module brc_sync #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             tglIn,
  input  logic [CNT_W-1:0] holdIn,
  output logic [CNT_W-1:0] countOut,
  output logic             validOut
);
  logic [SYNC_STAGES:0] syncQ;
  logic                 edgeSeen;

  assign edgeSeen = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      countOut <= '0;
      validOut <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-1:0], tglIn};
      validOut <= edgeSeen;
      if (edgeSeen) countOut <= holdIn;
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    validOut |=> !validOut);

  // R7
  count_hold_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !$stable(countOut) |-> validOut);
endmodule

// File: rtl/beat_run_counter.sv
module beat_run_counter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sampleClk,
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             sampleIn,
  output logic [CNT_W-1:0] countOut,
  output logic             validOut
);
  import brc_pkg::*;

  brc_strobe_t      strobes;
  logic [CNT_W-1:0] holdBus;
  logic             tglBus;

  brc_ctrl u_ctrl (
    .sampleClk(sampleClk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .strobes  (strobes)
  );

  brc_dpath #(.CNT_W(CNT_W)) u_dpath (
    .sampleClk(sampleClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .holdOut  (holdBus),
    .tglOut   (tglBus)
  );

  brc_sync #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .tglIn   (tglBus),
    .holdIn  (holdBus),
    .countOut(countOut),
    .validOut(validOut)
  );
endmodule

// File: tb/beat_run_counter_test.sv
module beat_run_counter_test;
  localparam int CW  = 8;
  localparam int GAP = 16;

  logic          sampleClk = 1'b0;
  logic          sysClk    = 1'b0;
  logic          rstN      = 1'b0;
  logic          sampleIn  = 1'b0;
  logic [CW-1:0] countOut;
  logic          validOut;

  int checks = 0;
  int errors = 0;
  int nGot   = 0;
  int nExp   = 0;
  logic [CW-1:0] got [0:1023];
  logic [CW-1:0] prevCount = '0;
  logic          prevValid = 1'b0;
  logic          started   = 1'b0;
  int            wdog      = 0;

  always #4    sysClk    = ~sysClk;     // 125 MHz
  always #4.85 sampleClk = ~sampleClk;

  beat_run_counter #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
    .sampleClk(sampleClk),
    .sysClk   (sysClk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .countOut (countOut),
    .validOut (validOut)
  );

  function automatic logic [CW-1:0] expCount(int n);
    if (n < 128) return CW'(n);
    return CW'(128 + (n % 128));
  endfunction

  task automatic check(string req, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: away from the system clock's active edge
  always @(negedge sysClk) begin
    if (started) begin
      if (validOut) begin
        got[nGot] = countOut;
        nGot = nGot + 1;
      end
      // R6 pulse lasts one cycle
      if (validOut && prevValid) check("R6", 1'b0, 1, 0);
      // R7 count changes only with valid
      if (countOut != prevCount && !validOut) check("R7", 1'b0, int'(countOut), int'(prevCount));
    end
    prevValid = validOut;
    prevCount = countOut;
    wdog = wdog + 1;
    if (wdog > 190000) begin
      check("R6 watchdog", 1'b0, wdog, 190000);
      finishRun();
    end
  end

  task automatic ones(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sampleClk);
      sampleIn = 1'b1;
    end
  endtask

  task automatic zeros(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sampleClk);
      sampleIn = 1'b0;
    end
  endtask

  task automatic runCheck(int n, string req);
    ones(n);
    zeros(GAP);
    // R6 exactly one report for this run
    check(req, nGot == nExp + 1, nGot - nExp, 1);
    if (nGot > nExp) check(req, got[nExp] == expCount(n), int'(got[nExp]), int'(expCount(n)));
    nExp = nGot;
  endtask

  initial begin
    int seedv;
    seedv = $urandom(32'h5eed1234);
    repeat (5) @(negedge sysClk);
    // R1 reset state
    check("R1 valid", validOut == 1'b0, int'(validOut), 0);
    check("R1 count", countOut == '0, int'(countOut), 0);
    rstN = 1'b1;
    started = 1'b1;
    zeros(GAP);

    runCheck(1, "R4");
    runCheck(2, "R2");
    runCheck(127, "R2");
    runCheck(128, "R3");
    runCheck(255, "R3");
    runCheck(256, "R3");
    runCheck(300, "R3");
    runCheck(400, "R3");

    // R5 long zeros give no report
    zeros(300);
    check("R5", nGot == nExp, nGot - nExp, 0);
    check("R5 count", countOut == expCount(400), int'(countOut), int'(expCount(400)));

    // R8 one zero splits two runs
    ones(20);
    zeros(1);
    ones(30);
    zeros(GAP);
    check("R8 reports", nGot == nExp + 2, nGot - nExp, 2);
    if (nGot >= nExp + 2) begin
      check("R8 first", got[nExp] == 8'd20, int'(got[nExp]), 20);
      check("R8 second", got[nExp+1] == 8'd30, int'(got[nExp+1]), 30);
    end
    nExp = nGot;

    for (int k = 0; k < 120; k++) begin
      int len;
      len = 1 + int'($urandom_range(299));
      if (len < 128) runCheck(len, "R2");
      else runCheck(len, "R3");
      zeros(int'($urandom_range(20)));
    end
    check("R5 tail", nGot == nExp, nGot - nExp, 0);

    finishRun();
  end
endmodule